// File: doc/BRIEF.md
# Serial Link Transmit Front End

This block sits between a character FIFO and a serial line driver. It runs on a bit-rate clock and keeps its own byte phase: a free-running counter splits every ten bit periods into one byte slot. At each slot boundary it either takes a 10-bit code word that the upstream encoder has already produced, or, when the active-low enable is not asserted, substitutes a K28.5 comma character. The comma is sent in the polarity that balances the line. Its running disparity is tracked from the ones count of every word that goes out.

The chosen word is shifted out one bit per clock, bit `a` first, through a fixed delay line. That delay line sets the latency from capture to the first serial bit. For every slot whose word was taken from the FIFO, an active-low read strobe is driven back to the FIFO. It is low for the first six bit periods of the slot and high for the last four. A byte-rate clock output marks the slot phase for the upstream logic.

Top module: `sl_tx_front`

## Requirements
- R1: The byte phase counter steps 0,1,...,9,0 on every clock edge. `byte_clk_o` is high while the count is 0 to 4 and low while it is 5 to 9. The count is 0 after reset.
- R2: A word on `word_i` is captured only at the edge where the count goes from 9 to 0, and only if `enable_ni` is low at that edge.
- R3: `rd_strobe_no` is low while the count is 0 to 5 in a slot whose word was captured at its start. In every other case it is high.
- R4: A slot with no captured word carries K28.5. The form is 10'b0011111010 when the running disparity is negative and 10'b1100000101 when it is positive.
- R5: The running disparity is updated when each word is loaded, data or comma. It becomes positive if the word has more than five ones, negative if it has fewer, and is unchanged at exactly five.
- R6: Each 10-bit word is sent in ten consecutive clock periods, `word_i[9]` (bit a) first and `word_i[0]` last.
- R7: Bit a of a word appears on `serial_o` directly after the 21st clock edge following its capture edge.
- R8: While reset is asserted, `serial_o` is low, `rd_strobe_no` is high, `byte_clk_o` is high and the running disparity is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_ni | input | 1 | Active-low word enable, sampled at the slot boundary |
| word_i | input | 10 | Encoded code word, bit 9 is bit a |
| byte_clk_o | output | 1 | Byte-rate clock, high for counts 0 to 4 |
| rd_strobe_no | output | 1 | Active-low FIFO read strobe |
| serial_o | output | 1 | Serial bit stream |

## Verification
At a slot boundary, three things happen on the same edge. The loading of the next word, the decision to insert a comma, and the disparity update from the previous word all coincide, and the comma's polarity depends on the disparity just settled. The bench provokes this by sending enabled words with six or more ones, or four or fewer, directly followed by idle slots, and by runs of back-to-back idle slots. It judges every serial bit against a model that recomputes the disparity from the ones count of each word it schedules. In the same cycle the read strobe falls for a newly captured slot; it is checked cycle by cycle against the slot's enable.

// File: rtl/sl_tx_pkg.sv
package sl_tx_pkg;
  localparam int unsigned CODE_W = 10;
  localparam logic [CODE_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CODE_W-1:0] COMMA_POS = 10'b1100000101;

  typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} disp_e;

  function automatic int unsigned ones_of(input logic [CODE_W-1:0] w);
    int unsigned n;
    n = 0;
    for (int i = 0; i < CODE_W; i++) n += int'(w[i]);
    return n;
  endfunction
endpackage

// File: rtl/sl_bit_counter.sv
module sl_bit_counter #(
  parameter int unsigned BITS  = 10,
  localparam int unsigned CW   = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o    = (cnt_q == LAST);
  assign cnt_nxt_o = last_o ? '0 : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/sl_word_select.sv
module sl_word_select
  import sl_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              enable_ni,
  input  logic [CODE_W-1:0] word_i,
  output logic [CODE_W-1:0] sel_word_o,
  output logic              sel_idle_o,
  output logic              valid_nxt_o,
  output disp_e             disp_o
);
  logic  valid_q;
  disp_e disp_q, disp_nxt;
  int unsigned n_ones;

  assign sel_idle_o  = enable_ni;
  assign valid_nxt_o = load_i ? !enable_ni : valid_q;
  assign disp_o      = disp_q;

  always_comb begin
    if (!enable_ni)              sel_word_o = word_i;
    else if (disp_q == RD_NEG)   sel_word_o = COMMA_NEG;
    else                         sel_word_o = COMMA_POS;
    n_ones = ones_of(sel_word_o);
    if (n_ones > CODE_W / 2)      disp_nxt = RD_POS;
    else if (n_ones < CODE_W / 2) disp_nxt = RD_NEG;
    else                          disp_nxt = disp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      disp_q  <= RD_NEG;
    end else if (load_i) begin
      valid_q <= !enable_ni;
      disp_q  <= disp_nxt;
    end
  end
endmodule

// File: rtl/sl_serializer.sv
module sl_serializer #(
  parameter int unsigned W       = 10,
  parameter int unsigned LATENCY = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         serial_o
);
  logic [W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shreg_q <= '0;
    else if (load_i) shreg_q <= word_i;
    else             shreg_q <= {shreg_q[W-2:0], 1'b0};
  end

  generate
    if (LATENCY == 0) begin : g_nodly
      assign serial_o = shreg_q[W-1];
    end else if (LATENCY == 1) begin : g_dly1
      logic dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= 1'b0;
        else         dly_q <= shreg_q[W-1];
      end
      assign serial_o = dly_q;
    end else begin : g_dlyn
      logic [LATENCY-1:0] dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q[LATENCY-2:0], shreg_q[W-1]};
      end
      assign serial_o = dly_q[LATENCY-1];
    end
  endgenerate
endmodule

// File: rtl/sl_tx_front.sv
module sl_tx_front
  import sl_tx_pkg::*;
#(
  parameter int unsigned LATENCY    = 21,
  parameter int unsigned STROBE_LOW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_ni,
  input  logic [CODE_W-1:0] word_i,
  output logic              byte_clk_o,
  output logic              rd_strobe_no,
  output logic              serial_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W);
  localparam int unsigned HALF  = CODE_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             load;
  logic [CODE_W-1:0] sel_word;
  logic             sel_idle;
  logic             valid_nxt;
  disp_e            disp_q;
  logic             strobe_q, bclk_q;

  sl_bit_counter #(.BITS(CODE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .last_o    (load)
  );

  sl_word_select u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .enable_ni   (enable_ni),
    .word_i      (word_i),
    .sel_word_o  (sel_word),
    .sel_idle_o  (sel_idle),
    .valid_nxt_o (valid_nxt),
    .disp_o      (disp_q)
  );

  sl_serializer #(.W(CODE_W), .LATENCY(LATENCY)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   (sel_word),
    .serial_o (serial_o)
  );

  // registered so the strobe and byte clock are glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      bclk_q   <= 1'b1;
    end else begin
      strobe_q <= !(valid_nxt && (cnt_nxt < CNT_W'(STROBE_LOW)));
      bclk_q   <= (cnt_nxt < CNT_W'(HALF));
    end
  end

  assign rd_strobe_no = strobe_q;
  assign byte_clk_o   = bclk_q;
endmodule

// File: rtl/sl_tx_front_chk.sv
module sl_tx_front_chk
  import sl_tx_pkg::*;
#(
  parameter int unsigned STROBE_LOW = 6,
  parameter int unsigned CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_q,
  input logic             load,
  input logic             sel_idle,
  input disp_e            disp_q,
  input logic             rd_strobe_no,
  input logic             byte_clk_o
);
  assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_q == '0));

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CODE_W - 1));

  assert_bclk_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_clk_o) |-> (cnt_q == '0));

  assert_strobe_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_no |-> (cnt_q < CNT_W'(STROBE_LOW)));

  assert_strobe_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_strobe_no) |-> (cnt_q == '0));

  assert_comma_flips_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && sel_idle) |=> (disp_q != $past(disp_q)));
endmodule

bind sl_tx_front sl_tx_front_chk #(
  .STROBE_LOW (STROBE_LOW),
  .CNT_W      (CNT_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_q        (cnt_q),
  .load         (load),
  .sel_idle     (sel_idle),
  .disp_q       (disp_q),
  .rd_strobe_no (rd_strobe_no),
  .byte_clk_o   (byte_clk_o)
);

// File: tb/sl_tx_front_tb_top.sv
module sl_tx_front_tb_top;
  localparam int LAT  = 21;
  localparam int NEXP = 4096;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_ni = 1'b1;
  logic [9:0] word_i = '0;
  logic       byte_clk_o, rd_strobe_no, serial_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic exp_bit [NEXP];
  logic exp_data [NEXP];
  int   n = 0;
  bit   m_disp = 0;
  bit   m_valid = 0;

  always #10 clk_i = ~clk_i;

  sl_tx_front dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_ni(enable_ni), .word_i(word_i),
    .byte_clk_o(byte_clk_o), .rd_strobe_no(rd_strobe_no), .serial_o(serial_o)
  );

  function automatic int ones(input logic [9:0] w);
    int c = 0;
    for (int i = 0; i < 10; i++) c += int'(w[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, n, act, exp);
    end
  endtask

  // drive, advance one edge, update the model, check after the edge
  task automatic step(input logic en_n, input logic [9:0] w);
    logic [9:0] sent;
    word_i    = w;
    enable_ni = en_n;
    @(posedge clk_i);
    n++;
    if (n % 10 == 0) begin
      m_valid = !en_n;
      if (!en_n) sent = w;
      else       sent = m_disp ? 10'b1100000101 : 10'b0011111010;
      if (ones(sent) > 5)      m_disp = 1;
      else if (ones(sent) < 5) m_disp = 0;
      for (int j = 0; j < 10; j++)
        if (n + LAT + j < NEXP) begin
          exp_bit[n + LAT + j]  = sent[9 - j];
          exp_data[n + LAT + j] = !en_n;
        end
    end
    @(negedge clk_i);
    check("R1 byte_clk", byte_clk_o, (n % 10) < 5);
    check("R3 strobe", rd_strobe_no, !(m_valid && (n % 10) < 6));
    if (n < NEXP)
      check(exp_data[n] ? "R2 R6 R7 data bit" : "R4 R5 R7 comma bit",
            serial_o, exp_bit[n]);
  endtask

  initial begin
    for (int i = 0; i < NEXP; i++) begin
      exp_bit[i] = 1'b0;
      exp_data[i] = 1'b0;
    end
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    check("R8 serial in reset", serial_o, 1'b0);
    check("R8 strobe in reset", rd_strobe_no, 1'b1);
    check("R8 byte_clk in reset", byte_clk_o, 1'b1);
    rst_ni = 1'b1;
    // idle run: comma polarity must alternate (R4, R5)
    for (int i = 0; i < 80; i++) step(1'b1, 10'h3FF);
    // heavy word then idle: comma must start positive form
    for (int i = 0; i < 10; i++) step(1'b0, 10'b1111110001);
    for (int i = 0; i < 30; i++) step(1'b1, 10'h000);
    // light word then idle
    for (int i = 0; i < 10; i++) step(1'b0, 10'b0000110001);
    for (int i = 0; i < 20; i++) step(1'b1, 10'h000);
    // balanced words leave disparity unchanged
    for (int i = 0; i < 30; i++) step(1'b0, 10'b1010101010);
    for (int i = 0; i < 20; i++) step(1'b1, 10'h000);
    // back-to-back enabled slots, strobe every slot
    for (int i = 0; i < 60; i++) step(1'b0, 10'($urandom));
    // enable toggling off-boundary must be ignored (R2)
    for (int i = 0; i < 40; i++) step(((i % 10) == 9) ? 1'b1 : 1'b0, 10'h2AA);
    // random mix
    for (int i = 0; i < 3000; i++) step(1'($urandom), 10'($urandom));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d actual hung expected done", n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule